// File: doc/BRIEF.md
# Comb/Bypass Mode Controller

This block is the digital control logic that decides whether a video luma/chroma separation path runs in its filtering (COMB) mode or in pass-through (BYPASS). It samples a mode-request pin and a select pin that together set the request polarity and the entry rule. The request is accepted only after its level has been steady for a set number of clock cycles, so a request pin tied to a subcarrier-rate signal follows only the DC level of that signal.

Leaving COMB is always immediate. The clock/PLL run enable drops in the same cycle as the mode. How COMB is entered depends on the select pin. With the select pin low, COMB is entered directly. With the select pin high, the block first moves to a waiting state where the clocks already run, and then enters COMB on the next vertical sync rising edge. A settled flag reports when the path has had time to stabilise after a mode change: one line pulse after entering BYPASS, and one vertical pulse after entering COMB. The block drives the switch selects of the chroma, luma and composite outputs and a comb-active status flag.

Top module: `comb_mode_ctrl`

## Requirements
- R1: With the select pin low, a steady low request gives COMB and a steady high request gives BYPASS.
- R2: With the select pin high, the polarity is inverted: a steady high request gives COMB and a steady low request gives BYPASS.
- R3: With the select pin low, COMB is entered with no vertical pulse. The mode reads COMB (code 2) no later than STABLE_CYCLES+4 clock cycles after the request pin changes.
- R4: With the select pin high, an accepted COMB request puts the mode in the waiting state (code 1) and keeps comb_active_o low until a vertical rising edge occurs. The mode then reads COMB within 4 cycles of that edge.
- R5: BYPASS (code 0) is entered with no vertical pulse, from either COMB or the waiting state, whatever the select pin is.
- R6: clk_run_o is low whenever the accepted request level is BYPASS. It is high in the waiting state and in COMB.
- R7: The path selects chroma_sel_o, luma_sel_o and cvbs_sel_o are 0 (direct routing from the inputs) in BYPASS and in the waiting state. They are 1 (processed path) in COMB.
- R8: A new request level takes effect only after it has held for STABLE_CYCLES consecutive cycles. Shorter pulses and toggling at every clock leave the mode unchanged.
- R9: settled_o clears on every mode change. After entering BYPASS it rises on the first line rising edge. After entering COMB it rises on the first vertical rising edge after entry. It stays low in the waiting state.
- R10: After reset the mode is BYPASS, and clk_run_o, comb_active_o, settled_o and all path selects are low.
- R11: comb_active_o is high exactly when the mode is COMB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 1 | Asynchronous mode-request pin |
| pol_sync_i | input | 1 | Asynchronous select pin: request polarity and entry rule |
| vsync_i | input | 1 | Asynchronous vertical sync pulse, rising-edge active |
| hline_i | input | 1 | Asynchronous line pulse, rising-edge active |
| mode_o | output | 2 | Mode: 0 BYPASS, 1 waiting, 2 COMB |
| clk_run_o | output | 1 | Clock/PLL run enable |
| chroma_sel_o | output | 1 | Chroma output switch: 1 processed, 0 external chroma input |
| luma_sel_o | output | 1 | Luma output switch: 1 processed, 0 luma/composite input |
| cvbs_sel_o | output | 1 | Composite output switch: 1 processed, 0 luma/composite input |
| comb_active_o | output | 1 | High while COMB is active |
| settled_o | output | 1 | Settling after the last mode change is complete |

## Verification
The assertions assume that every input reaches the logic through the two-flop synchronisers, so each sync input holds at least two clock cycles before the logic responds to it. They also assume that a vertical or line pulse stays high for at least one sampled cycle, so that it produces exactly one rising edge. The stimulus drives every pin on the falling clock edge and holds sync pulses high for two cycles. It changes the request and select pins together only when the new pair encodes a single intended level. Pulses and toggles shorter than the filter window are kept strictly below STABLE_CYCLES cycles.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_COMB = 2'd2
  } cmc_mode_e;
endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cmc_edge.sv
module cmc_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/cmc_level_filter.sv
module cmc_level_filter #(
  parameter int   STABLE_CYCLES = 8,
  parameter logic RESET_LEVEL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= RESET_LEVEL;
    end else if (raw_i == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= raw_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // A change of the accepted level needs the raw input at that level on the prior cycle
  AST_FILT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(raw_i) == level_q)); // R8
  AST_FILT_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST); // R8
endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
  import cmc_pkg::*;
#(
  parameter int N_PATHS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               want_comb_i,
  input  logic               sync_entry_i,
  input  logic               vs_rise_i,
  input  logic               ln_rise_i,
  output cmc_mode_e          mode_o,
  output logic               clk_run_o,
  output logic [N_PATHS-1:0] path_sel_o,
  output logic               comb_o,
  output logic               settled_o
);
  cmc_mode_e          st_q, st_d;
  logic               run_q;
  logic [N_PATHS-1:0] sel_q;
  logic               comb_q;
  logic               settled_q;
  logic               settle_evt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MODE_BYP: begin
        if (want_comb_i) st_d = sync_entry_i ? MODE_WAIT : MODE_COMB;
      end
      MODE_WAIT: begin
        if (!want_comb_i)   st_d = MODE_BYP;
        else if (vs_rise_i) st_d = MODE_COMB;
      end
      MODE_COMB: begin
        if (!want_comb_i) st_d = MODE_BYP;
      end
      default: st_d = MODE_BYP;
    endcase
  end

  always_comb begin
    settle_evt = 1'b0;
    if (st_q == MODE_BYP)  settle_evt = ln_rise_i;
    if (st_q == MODE_COMB) settle_evt = vs_rise_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= MODE_BYP;
      run_q     <= 1'b0;
      sel_q     <= '0;
      comb_q    <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      run_q  <= (st_d != MODE_BYP);
      sel_q  <= {N_PATHS{st_d == MODE_COMB}};
      comb_q <= (st_d == MODE_COMB);
      if (st_d != st_q)   settled_q <= 1'b0;
      else if (settle_evt) settled_q <= 1'b1;
    end
  end

  assign mode_o     = st_q;
  assign clk_run_o  = run_q;
  assign path_sel_o = sel_q;
  assign comb_o     = comb_q;
  assign settled_o  = settled_q;

  AST_EXIT_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    !want_comb_i |=> (st_q == MODE_BYP)); // R5
  AST_CLK_STOP: assert property (@(posedge clk) disable iff (rst)
    !want_comb_i |=> !run_q); // R6
  AST_WAIT_FOR_VS: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_WAIT && !vs_rise_i) |=> (st_q != MODE_COMB)); // R4
  AST_DIRECT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_BYP && want_comb_i && !sync_entry_i) |=> (st_q == MODE_COMB)); // R3
  AST_BYP_ROUTES: assert property (@(posedge clk) disable iff (rst)
    !comb_q |-> (sel_q == '0)); // R7
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    comb_q == (st_q == MODE_COMB)); // R11
  AST_SETTLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st_q != $past(st_q)) |-> !settled_q); // R9
endmodule

// File: rtl/comb_mode_ctrl.sv
module comb_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_req_i,
  input  logic       pol_sync_i,
  input  logic       vsync_i,
  input  logic       hline_i,
  output logic [1:0] mode_o,
  output logic       clk_run_o,
  output logic       chroma_sel_o,
  output logic       luma_sel_o,
  output logic       cvbs_sel_o,
  output logic       comb_active_o,
  output logic       settled_o
);
  localparam int N_SYNC  = 4;
  localparam int N_EDGE  = 2;
  localparam int N_PATHS = 3;

  logic [N_SYNC-1:0]  pins_s;
  logic [N_EDGE-1:0]  rises;
  logic               want_raw, want_f;
  cmc_mode_e          mode_e;
  logic [N_PATHS-1:0] sel;

  cmc_sync #(.W(N_SYNC)) u_sync (
    .clk (clk), .rst (rst),
    .d_i ({hline_i, vsync_i, pol_sync_i, mode_req_i}),
    .q_o (pins_s)
  );

  cmc_edge #(.W(N_EDGE)) u_edge (
    .clk (clk), .rst (rst),
    .lvl_i  (pins_s[3:2]),
    .rise_o (rises)
  );

  // COMB is requested when the request level equals the select level
  assign want_raw = (pins_s[0] == pins_s[1]);

  cmc_level_filter #(.STABLE_CYCLES(STABLE_CYCLES), .RESET_LEVEL(1'b0)) u_filt (
    .clk (clk), .rst (rst),
    .raw_i   (want_raw),
    .level_o (want_f)
  );

  cmc_mode_fsm #(.N_PATHS(N_PATHS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .want_comb_i  (want_f),
    .sync_entry_i (pins_s[1]),
    .vs_rise_i    (rises[0]),
    .ln_rise_i    (rises[1]),
    .mode_o       (mode_e),
    .clk_run_o    (clk_run_o),
    .path_sel_o   (sel),
    .comb_o       (comb_active_o),
    .settled_o    (settled_o)
  );

  assign mode_o       = mode_e;
  assign chroma_sel_o = sel[0];
  assign luma_sel_o   = sel[1];
  assign cvbs_sel_o   = sel[2];
endmodule

// File: tb/sim_comb_mode_ctrl.sv
module sim_comb_mode_ctrl;
  localparam int PERIOD = 10;
  localparam int STB    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b1, pol = 1'b0, vs = 1'b0, ln = 1'b0;
  logic [1:0] mode;
  logic run, csel, ysel, vsel, act, setl;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  comb_mode_ctrl #(.STABLE_CYCLES(STB)) u0 (
    .clk(clk), .rst(rst), .mode_req_i(req), .pol_sync_i(pol),
    .vsync_i(vs), .hline_i(ln), .mode_o(mode), .clk_run_o(run),
    .chroma_sel_o(csel), .luma_sel_o(ysel), .cvbs_sel_o(vsel),
    .comb_active_o(act), .settled_o(setl)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic chk_state(input string tag, input int m);
    int sel_exp;
    sel_exp = (m == 2) ? 7 : 0;
    chk(mode == 2'(m), tag, mode, m);
    chk(run == (m != 0), {tag, " R6 run"}, run, m != 0);
    chk({vsel, ysel, csel} == 3'(sel_exp), {tag, " R7 sel"}, {vsel, ysel, csel}, sel_exp);
    chk(act == (m == 2), {tag, " R11 act"}, act, m == 2);
  endtask

  task automatic pulse_vs();
    vs = 1'b1; cyc(2); vs = 1'b0; cyc(4);
  endtask

  task automatic pulse_ln();
    ln = 1'b1; cyc(2); ln = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    chk_state("R10 reset", 0);
    chk(setl == 1'b0, "R10 settled", setl, 0);
  endtask

  task automatic t_direct_entry();
    pol = 1'b0; req = 1'b0;
    cyc(STB + 1);
    chk(mode == 2'd0, "R8 not before window", mode, 0);
    cyc(3);
    chk_state("R3 R1 direct comb", 2);
    chk(setl == 1'b0, "R9 settled low after entry", setl, 0);
    pulse_ln();
    chk(setl == 1'b0, "R9 line ignored in comb", setl, 0);
    pulse_vs();
    chk(setl == 1'b1, "R9 settled after vs", setl, 1);
  endtask

  task automatic t_glitch_in_comb();
    req = 1'b1; cyc(STB - 1); req = 1'b0; cyc(STB + 4);
    chk_state("R8 short pulse ignored", 2);
    for (int i = 0; i < 60; i++) begin req = ~req; cyc(1); end
    req = 1'b0; cyc(STB + 4);
    chk_state("R8 toggling ignored in comb", 2);
  endtask

  task automatic t_exit();
    req = 1'b1; cyc(STB + 4);
    chk_state("R5 R1 exit to bypass", 0);
    chk(setl == 1'b0, "R9 settled cleared on exit", setl, 0);
    pulse_vs();
    chk(setl == 1'b0, "R9 vs ignored in bypass", setl, 0);
    pulse_ln();
    chk(setl == 1'b1, "R9 settled after line", setl, 1);
  endtask

  task automatic t_toggle_in_bypass();
    for (int i = 0; i < 60; i++) begin req = ~req; cyc(1); end
    req = 1'b1; cyc(STB + 4);
    chk_state("R8 toggling ignored in bypass", 0);
  endtask

  task automatic t_sync_entry();
    pol = 1'b1; req = 1'b1; cyc(STB + 4);
    chk_state("R4 R2 waiting", 1);
    chk(setl == 1'b0, "R9 low while waiting", setl, 0);
    cyc(20);
    chk_state("R4 still waiting without vs", 1);
    pulse_vs();
    chk_state("R4 comb after vs", 2);
    chk(setl == 1'b0, "R9 entry edge not counted", setl, 0);
    pulse_vs();
    chk(setl == 1'b1, "R9 settled after next vs", setl, 1);
  endtask

  task automatic t_sync_exit();
    req = 1'b0; cyc(STB + 4);
    chk_state("R5 R2 exit with select high", 0);
    req = 1'b1; cyc(STB + 4);
    chk_state("R4 waiting again", 1);
    req = 1'b0; cyc(STB + 4);
    chk_state("R5 abort from waiting", 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_direct_entry();
    t_glitch_in_comb();
    t_exit();
    t_toggle_in_bypass();
    t_sync_entry();
    t_sync_exit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule